// File: doc/BRIEF.md
# Cartridge Copier Control and Vector Redirect

This block is the register and address-decode logic of a console cartridge copier. It sits on a 16-bit CPU address bus with an 8-bit data bus. Four registers lie at the very top of the low RAM window, from $3FFC to $3FFF: control, bank, byte port and status. Under control of those registers, the block steers the CPU's NMI and IRQ vector fetches, and stores to the same addresses, either to cartridge ROM or to copier RAM.

The block has two mapping modes. In the simple whole-bank mode, any write into ROM space loads the bank register directly. In pass-through mode, ROM-space writes go out as strobes to an external scanline-counter mapper, and that mapper is not part of this block. From the registers the block drives the 32 KB PRG bank from copier memory, the nametable mirroring code and the CHR-RAM select.

A serial byte link reaches the block through a valid/ready receive channel and a valid/ready transmit channel. A read of status samples the receive side. A write to the byte port pushes one byte toward the host and stalls the CPU until that byte is taken.

Top module: `cart_copier_ctrl`

## Requirements
- R1: After reset, control reads $00, bank reads $08 and the byte port reads $00. Status holds $B0, so its first read returns $B1 when no receive byte is waiting. PRG comes from copier memory with bank 0, the mirroring code is 2'b01, CHR-RAM select is low and the NMI-block output is low.
- R2: A read or write with address $3FFC-$3FFF selects a register by address bits [1:0]: 0 control, 1 bank, 2 byte port, 3 status. A written control, bank or status value reads back unchanged, except that status bit0 reflects the receive sample taken by that read.
- R3: With control bit2 set, CPU reads and writes at $FFFA/$FFFB assert ram_cs with mem_addr $3FFC/$3FFD, and raise neither rom_cs nor a mapper strobe. With bit2 clear, reads there assert rom_cs and writes there follow the ROM-space write path.
- R4: With control bit1 set, accesses at $FFFE/$FFFF assert ram_cs with mem_addr $3FFE/$3FFF. With bit1 clear, reads there assert rom_cs.
- R5: With control bit4 set (simple bank mode), a write anywhere in $8000-$FFF9 loads the bank register with the data ANDed with $1F and raises no mapper strobe.
- R6: With control bit4 clear, ROM-space writes raise map_cmd_we below $C000 and map_irq_we at $C000 and above, and the bank register is unchanged.
- R7: Writes at $FFFC/$FFFD have no effect: no strobe, no select, and no register change.
- R8: prg_from_copier equals the inverse of control bit0, and prg_bank equals bank[3:0] XOR 4'b1000.
- R9: The mirroring code is {1, bank bit4} (single screen) in simple bank mode. In pass-through mode it is {0, inverse of data bit0 of the last mirroring write}. A mirroring write is a forwarded write at an even address in $A000-$BFFF.
- R10: chr_ram_sel is high exactly when status bit3 and control bit4 are both set.
- R11: A status read with a receive byte waiting pulses rx_ready, latches the byte into the byte-port register, and clears status bit0 both in the returned value and in the stored status. With no byte waiting, the read sets bit0.
- R12: A byte-port read returns the latched byte, does not pulse rx_ready and leaves status unchanged.
- R13: A byte-port write presents the data on tx_data with tx_valid, holds cpu_stall high while tx_ready is low, and changes no register.
- R14: The nmi_block output follows control bit3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, held while stalled |
| cpu_rdata | output | 8 | Register read data, zero outside the register window |
| cpu_stall | output | 1 | Byte-port write waiting for the transmit side |
| ram_cs | output | 1 | Copier RAM select |
| rom_cs | output | 1 | Cartridge ROM read select |
| mem_addr | output | 16 | Address toward RAM/ROM after vector redirect |
| map_cmd_we | output | 1 | Forwarded mapper command write |
| map_irq_we | output | 1 | Forwarded mapper counter write |
| prg_from_copier | output | 1 | PRG window sourced from copier memory |
| prg_bank | output | 4 | 32 KB copier PRG bank |
| mirror | output | 2 | Mirroring code |
| chr_ram_sel | output | 1 | Internal CHR-RAM selected |
| nmi_block | output | 1 | NMI disable |
| rx_valid | input | 1 | Receive byte waiting |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte taken |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit side accepts |

## Verification
The assertions assume that cpu_rd and cpu_wr are never high together. They also assume that a read strobe lasts one cycle per access, so the receive latch and the status update each happen once. The bench drives every strobe for one cycle only, and holds a write longer only while cpu_stall is high. It raises tx_ready during that wait. It changes rx_valid and rx_data only between accesses, never while a status read is in progress.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int BANK_W = 4;
    localparam int IDX_W  = 2;

    localparam logic [ADDR_W-1:0] REG_BASE = 16'h3FFC;
    localparam logic [ADDR_W-1:0] ROM_BASE = 16'h8000;
    localparam logic [ADDR_W-1:0] SPLIT    = 16'hC000;
    localparam logic [ADDR_W-1:0] MAP_LAST = 16'hFFF9;
    localparam logic [ADDR_W-1:0] NMI_VEC  = 16'hFFFA;
    localparam logic [ADDR_W-1:0] IRQ_VEC  = 16'hFFFE;
    localparam logic [ADDR_W-1:0] NMI_RAM  = REG_BASE;
    localparam logic [ADDR_W-1:0] IRQ_RAM  = REG_BASE + 16'd2;
    localparam logic [BANK_W-1:0] BANK_FLIP = 4'b1000;
    localparam logic [DATA_W-1:0] BANK_MASK = 8'h1F;

    typedef enum logic [IDX_W-1:0] {
        RG_CTRL = 2'd0,
        RG_BANK = 2'd1,
        RG_DATA = 2'd2,
        RG_STAT = 2'd3
    } reg_idx_e;

    typedef struct packed {
        logic [2:0] rsvd;
        logic       simple;
        logic       nmi_off;
        logic       nmi_redir;
        logic       irq_redir;
        logic       cart;
    } ctrl_t;

    typedef struct packed {
        logic vram;
        logic a10;
        logic nmi;
        logic irq;
        logic cart;
        logic pend;
        logic tx;
        logic rx_empty;
    } stat_t;

    typedef struct packed {
        logic ram_cs;
        logic rom_cs;
        logic reg_hit;
        logic bank_load;
        logic map_cmd;
        logic map_irq;
        logic mir_wr;
    } route_t;

    localparam ctrl_t             CTRL_RST = '0;
    localparam logic [DATA_W-1:0] BANK_RST = 8'h08;
    localparam stat_t             STAT_RST = 8'hB0;

    function automatic logic [ADDR_W-1:0] vec_target(input logic [ADDR_W-1:0] base,
                                                     input logic a0);
        return {base[ADDR_W-1:1], a0};
    endfunction

    function automatic logic [1:0] mirror_code(input logic simple, input logic bank_bit,
                                               input logic mir_bit);
        return simple ? {1'b1, bank_bit} : {1'b0, ~mir_bit};
    endfunction
endpackage

// File: rtl/ccc_decode.sv
module ccc_decode
    import ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    input  logic              simple,
    input  logic              nmi_redir,
    input  logic              irq_redir,
    output route_t            rt,
    output logic [ADDR_W-1:0] phys_addr
);
    logic in_reg, low_ram, in_rom, nmi_hit, irq_hit;
    logic nmi_go, irq_go, redir, map_area, mwr;

    always_comb begin
        in_reg   = addr[ADDR_W-1:IDX_W] == REG_BASE[ADDR_W-1:IDX_W];
        low_ram  = addr < REG_BASE;
        in_rom   = addr >= ROM_BASE;
        nmi_hit  = addr[ADDR_W-1:1] == NMI_VEC[ADDR_W-1:1];
        irq_hit  = addr[ADDR_W-1:1] == IRQ_VEC[ADDR_W-1:1];
        nmi_go   = nmi_hit && nmi_redir;
        irq_go   = irq_hit && irq_redir;
        redir    = nmi_go || irq_go;
        map_area = (in_rom && addr <= MAP_LAST) ||
                   (nmi_hit && !nmi_redir) || (irq_hit && !irq_redir);
        mwr      = wr && map_area;

        rt.ram_cs    = (rd || wr) && (low_ram || redir);
        rt.rom_cs    = rd && in_rom && !redir;
        rt.reg_hit   = (rd || wr) && in_reg;
        rt.bank_load = mwr && simple;
        rt.map_cmd   = mwr && !simple && (addr < SPLIT);
        rt.map_irq   = mwr && !simple && (addr >= SPLIT);
        rt.mir_wr    = rt.map_cmd && (addr[14:13] == 2'b01) && !addr[0];

        if (nmi_go)      phys_addr = vec_target(NMI_RAM, addr[0]);
        else if (irq_go) phys_addr = vec_target(IRQ_RAM, addr[0]);
        else             phys_addr = addr;
    end

    // R3: one destination at most per access
    p_route_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({rt.ram_cs, rt.rom_cs, rt.reg_hit, rt.bank_load, rt.map_cmd, rt.map_irq}));
endmodule

// File: rtl/ccc_regs.sv
module ccc_regs
    import ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic              reg_hit,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              bank_load,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    output logic              stall,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] bank_q,
    output stat_t             stat_q
);
    logic [DATA_W-1:0] data_q;
    logic stat_rd, data_rd, data_wr, reg_wr;
    stat_t stat_view;

    always_comb begin
        stat_rd  = reg_hit && rd && (reg_idx_e'(idx) == RG_STAT);
        data_rd  = reg_hit && rd && (reg_idx_e'(idx) == RG_DATA);
        data_wr  = reg_hit && wr && (reg_idx_e'(idx) == RG_DATA);
        reg_wr   = reg_hit && wr && (reg_idx_e'(idx) != RG_DATA);
        rx_ready = stat_rd && rx_valid;
        tx_valid = data_wr;
        tx_data  = wdata;
        stall    = data_wr && !tx_ready;
        stat_view = stat_q;
        if (stat_rd) stat_view.rx_empty = !rx_valid;
        rdata = '0;
        if (reg_hit && rd) begin
            unique case (reg_idx_e'(idx))
                RG_CTRL: rdata = ctrl_q;
                RG_BANK: rdata = bank_q;
                RG_DATA: rdata = data_q;
                RG_STAT: rdata = stat_view;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_RST;
            bank_q <= BANK_RST;
            stat_q <= STAT_RST;
            data_q <= '0;
        end else begin
            if (reg_wr) begin
                unique case (reg_idx_e'(idx))
                    RG_CTRL: ctrl_q <= ctrl_t'(wdata);
                    RG_BANK: bank_q <= wdata;
                    RG_STAT: stat_q <= stat_t'(wdata);
                    default: ;
                endcase
            end
            if (bank_load) bank_q <= wdata & BANK_MASK;
            if (stat_rd) begin
                stat_q.rx_empty <= !rx_valid;
                if (rx_valid) data_q <= rx_data;
            end
        end
    end

    // R11: a status read with a waiting byte latches it and clears the empty flag
    p_rx_latch_r11: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && rx_valid) |=> (data_q == $past(rx_data)) && !stat_q.rx_empty);
    // R12: a byte-port read leaves status and the latched byte alone
    p_data_rd_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        data_rd |=> $stable(stat_q) && $stable(data_q));
    // R5: simple-mode ROM write lands masked in the bank register
    p_bank_load_r5: assert property (@(posedge clk) disable iff (rst)
        bank_load |=> bank_q == ($past(wdata) & BANK_MASK));
    // R13: a byte-port push touches no register
    p_tx_no_reg_r13: assert property (@(posedge clk) disable iff (rst)
        tx_valid |=> $stable(ctrl_q) && $stable(bank_q) && $stable(stat_q));
endmodule

// File: rtl/ccc_map.sv
module ccc_map
    import ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              simple,
    input  logic              cart,
    input  logic              stat_cart,
    input  logic [BANK_W:0]   bank_lo,
    input  logic              mir_wr,
    input  logic              wbit,
    output logic              prg_from_copier,
    output logic [BANK_W-1:0] prg_bank,
    output logic [1:0]        mirror,
    output logic              chr_ram_sel
);
    logic mir_bit_q;

    always_ff @(posedge clk) begin
        if (rst)         mir_bit_q <= 1'b0;
        else if (mir_wr) mir_bit_q <= wbit;
    end

    always_comb begin
        prg_from_copier = !cart;
        prg_bank        = bank_lo[BANK_W-1:0] ^ BANK_FLIP;
        mirror          = mirror_code(simple, bank_lo[BANK_W], mir_bit_q);
        chr_ram_sel     = stat_cart && simple;
    end

    // R9: a pass-through mirroring write shows up inverted next cycle
    p_mirror_track_r9: assert property (@(posedge clk) disable iff (rst)
        mir_wr |=> mirror == {1'b0, ~$past(wbit)});
endmodule

// File: rtl/cart_copier_ctrl.sv
module cart_copier_ctrl
    import ccc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              ram_cs,
    output logic              rom_cs,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              map_cmd_we,
    output logic              map_irq_we,
    output logic              prg_from_copier,
    output logic [BANK_W-1:0] prg_bank,
    output logic [1:0]        mirror,
    output logic              chr_ram_sel,
    output logic              nmi_block,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_data,
    input  logic              tx_ready
);
    route_t            rt;
    ctrl_t             ctrl_q;
    stat_t             stat_q;
    logic [DATA_W-1:0] bank_q;

    ccc_decode i_decode (
        .clk(clk), .rst(rst), .addr(cpu_addr), .rd(cpu_rd), .wr(cpu_wr),
        .simple(ctrl_q.simple), .nmi_redir(ctrl_q.nmi_redir),
        .irq_redir(ctrl_q.irq_redir), .rt(rt), .phys_addr(mem_addr)
    );

    ccc_regs i_regs (
        .clk(clk), .rst(rst), .idx(cpu_addr[IDX_W-1:0]), .reg_hit(rt.reg_hit),
        .rd(cpu_rd), .wr(cpu_wr), .wdata(cpu_wdata), .bank_load(rt.bank_load),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .stall(cpu_stall), .rdata(cpu_rdata), .ctrl_q(ctrl_q),
        .bank_q(bank_q), .stat_q(stat_q)
    );

    ccc_map i_map (
        .clk(clk), .rst(rst), .simple(ctrl_q.simple), .cart(ctrl_q.cart),
        .stat_cart(stat_q.cart), .bank_lo(bank_q[BANK_W:0]), .mir_wr(rt.mir_wr),
        .wbit(cpu_wdata[0]), .prg_from_copier(prg_from_copier),
        .prg_bank(prg_bank), .mirror(mirror), .chr_ram_sel(chr_ram_sel)
    );

    always_comb begin
        ram_cs     = rt.ram_cs;
        rom_cs     = rt.rom_cs;
        map_cmd_we = rt.map_cmd;
        map_irq_we = rt.map_irq;
        nmi_block  = ctrl_q.nmi_off;
    end

    // R14: the NMI-block output tracks a control write on the next cycle
    p_nmi_block_r14: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && rt.reg_hit && cpu_addr[1:0] == 2'd0) |=> nmi_block == $past(cpu_wdata[3]));
endmodule

// File: tb/test_cart_copier_ctrl.sv
module test_cart_copier_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd, cpu_wr;
    logic [7:0]  cpu_rdata;
    logic        cpu_stall, ram_cs, rom_cs;
    logic [15:0] mem_addr;
    logic        map_cmd_we, map_irq_we, prg_from_copier;
    logic [3:0]  prg_bank;
    logic [1:0]  mirror;
    logic        chr_ram_sel, nmi_block;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        rx_ready, tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_copier_ctrl i_cart_copier_ctrl (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
        .ram_cs(ram_cs), .rom_cs(rom_cs), .mem_addr(mem_addr),
        .map_cmd_we(map_cmd_we), .map_irq_we(map_irq_we),
        .prg_from_copier(prg_from_copier), .prg_bank(prg_bank), .mirror(mirror),
        .chr_ram_sel(chr_ram_sel), .nmi_block(nmi_block), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // start an access at a falling edge; effects settle 1 time unit later
    task automatic start(input logic [15:0] a, input logic [7:0] d, input logic r, input logic w);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = r; cpu_wr = w;
        #1;
    endtask

    task automatic stop();
        @(negedge clk);
        cpu_rd = 0; cpu_wr = 0; cpu_addr = 16'h4000;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        start(a, d, 0, 1);
        stop();
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v);
        start(a, 8'h00, 1, 0);
        v = cpu_rdata;
        stop();
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 prg_from_copier", prg_from_copier, 1);
        chk("R1 prg_bank", prg_bank, 0);
        chk("R1 mirror", mirror, 2'b01);
        chk("R1 chr_ram_sel", chr_ram_sel, 0);
        chk("R1 nmi_block", nmi_block, 0);
        rd(16'h3FFC, v); chk("R1 ctrl", v, 8'h00);
        rd(16'h3FFD, v); chk("R1 bank", v, 8'h08);
        rd(16'h3FFE, v); chk("R1 data", v, 8'h00);
        rd(16'h3FFF, v); chk("R1 status", v, 8'hB1);
    endtask

    task automatic t_regs();
        logic [7:0] v;
        wr(16'h3FFD, 8'h15); rd(16'h3FFD, v); chk("R2 bank readback", v, 8'h15);
        chk("R8 prg_bank xor", prg_bank, 4'hD);
        wr(16'h3FFC, 8'h09); rd(16'h3FFC, v); chk("R2 ctrl readback", v, 8'h09);
        chk("R8 cart mapping", prg_from_copier, 0);
        chk("R14 nmi_block set", nmi_block, 1);
        wr(16'h3FFC, 8'h00);
        chk("R14 nmi_block clear", nmi_block, 0);
        wr(16'h3FFF, 8'h08); rd(16'h3FFF, v); chk("R2 status readback", v, 8'h09);
    endtask

    task automatic t_nmi();
        wr(16'h3FFC, 8'h04);
        start(16'hFFFB, 0, 1, 0);
        chk("R3 redirect read ram_cs", ram_cs, 1);
        chk("R3 redirect read addr", mem_addr, 16'h3FFD);
        chk("R3 redirect read rom_cs", rom_cs, 0);
        stop();
        start(16'hFFFA, 8'h55, 0, 1);
        chk("R3 redirect write ram_cs", ram_cs, 1);
        chk("R3 redirect write addr", mem_addr, 16'h3FFC);
        chk("R3 redirect write strobes", {map_cmd_we, map_irq_we}, 0);
        stop();
        wr(16'h3FFC, 8'h00);
        start(16'hFFFA, 0, 1, 0);
        chk("R3 plain read rom_cs", {rom_cs, ram_cs}, 2'b10);
        stop();
        start(16'hFFFA, 8'h00, 0, 1);
        chk("R3 plain write to mapper", map_irq_we, 1);
        stop();
    endtask

    task automatic t_irq();
        wr(16'h3FFC, 8'h02);
        start(16'hFFFF, 0, 1, 0);
        chk("R4 redirect ram_cs", {ram_cs, rom_cs}, 2'b10);
        chk("R4 redirect addr", mem_addr, 16'h3FFF);
        stop();
        start(16'hFFFE, 0, 1, 0);
        chk("R4 redirect addr even", mem_addr, 16'h3FFE);
        stop();
        wr(16'h3FFC, 8'h00);
        start(16'hFFFE, 0, 1, 0);
        chk("R4 plain read rom_cs", {ram_cs, rom_cs}, 2'b01);
        stop();
    endtask

    task automatic t_simple();
        logic [7:0] v;
        wr(16'h3FFC, 8'h10);
        chk("R10 chr_ram_sel both", chr_ram_sel, 1);
        start(16'h8000, 8'hF7, 0, 1);
        chk("R5 no strobes", {map_cmd_we, map_irq_we}, 0);
        stop();
        rd(16'h3FFD, v); chk("R5 bank masked", v, 8'h17);
        chk("R9 single screen hi", mirror, 2'b11);
        wr(16'hFFF9, 8'h03);
        rd(16'h3FFD, v); chk("R5 bank at top", v, 8'h03);
        chk("R9 single screen lo", mirror, 2'b10);
        wr(16'h3FFC, 8'h00);
        chk("R10 chr_ram_sel off", chr_ram_sel, 0);
    endtask

    task automatic t_pass();
        logic [7:0] v;
        start(16'h9000, 8'h11, 0, 1);
        chk("R6 cmd strobe", {map_cmd_we, map_irq_we}, 2'b10);
        stop();
        start(16'hC001, 8'h22, 0, 1);
        chk("R6 irq strobe", {map_cmd_we, map_irq_we}, 2'b01);
        stop();
        rd(16'h3FFD, v); chk("R6 bank unchanged", v, 8'h03);
        wr(16'hA000, 8'h01); chk("R9 mirror from write 1", mirror, 2'b00);
        wr(16'hA001, 8'h00); chk("R9 odd address ignored", mirror, 2'b00);
        wr(16'hA000, 8'h00); chk("R9 mirror from write 0", mirror, 2'b01);
    endtask

    task automatic t_ignore();
        logic [7:0] v;
        wr(16'h3FFC, 8'h10);
        start(16'hFFFC, 8'h1F, 0, 1);
        chk("R7 no select", {ram_cs, rom_cs, map_cmd_we, map_irq_we}, 0);
        stop();
        rd(16'h3FFD, v); chk("R7 bank unchanged", v, 8'h03);
        wr(16'h3FFC, 8'h00);
    endtask

    task automatic t_rx();
        logic [7:0] v;
        rx_valid = 1; rx_data = 8'h5A;
        start(16'h3FFF, 0, 1, 0);
        chk("R11 status with byte", cpu_rdata, 8'h08);
        chk("R11 pop", rx_ready, 1);
        stop();
        rx_valid = 0;
        rd(16'h3FFE, v); chk("R11 byte latched", v, 8'h5A);
        rx_valid = 1; rx_data = 8'h77;
        start(16'h3FFE, 0, 1, 0);
        chk("R12 no pop on data read", rx_ready, 0);
        chk("R12 data read value", cpu_rdata, 8'h5A);
        stop();
        rx_valid = 0;
        rd(16'h3FFE, v); chk("R12 byte kept", v, 8'h5A);
        rd(16'h3FFF, v); chk("R11 status empty", v, 8'h09);
    endtask

    task automatic t_tx();
        logic [7:0] v;
        tx_ready = 0;
        start(16'h3FFE, 8'hC3, 0, 1);
        chk("R13 tx_valid", tx_valid, 1);
        chk("R13 tx_data", tx_data, 8'hC3);
        chk("R13 stall", cpu_stall, 1);
        @(negedge clk); #1;
        chk("R13 stall held", cpu_stall, 1);
        tx_ready = 1; #1;
        chk("R13 stall released", cpu_stall, 0);
        stop();
        tx_ready = 0;
        rd(16'h3FFE, v); chk("R13 data reg untouched", v, 8'h5A);
        rd(16'h3FFC, v); chk("R13 ctrl untouched", v, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1; cpu_addr = 16'h4000; cpu_wdata = 0; cpu_rd = 0; cpu_wr = 0;
        rx_valid = 0; rx_data = 0; tx_ready = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_regs();
        t_nmi();
        t_irq();
        t_simple();
        t_pass();
        t_ignore();
        t_rx();
        t_tx();
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule